// File: doc/BRIEF.md
# UART Receive Word Packer with Stale Flush

This block sits behind a UART deserializer. It takes received bytes one at a time and packs them four to a 32-bit word, with the earliest byte in the least significant lane. Each completed word enters an eight-word receive queue. Software reads the queue through a data register on a simple register bus.

Software can see how many bytes are waiting in the partially filled packing word. It can also issue a "force stale" command that closes that partial word and pushes it into the queue. This gives software access to the tail of a message that is shorter than a whole word. A stale flush raises a stale flag, shown on an output pin, and ends the current reception. Reception resumes when a new length is written. The block also provides an armed receive-length counter, an overrun flag, and commands to clear errors and to reset the receiver.

The bus read data is combinational: it is valid in the same cycle as `busRead`. Every write, pop and byte takes effect at the next rising clock edge.

Top module: `uartRxPacker`

## Requirements
- R1: An accepted byte goes into lane k of the packing word, bits [8k+7:8k], where k is the current partial count (0 to 3). The byte that fills lane 3 completes the word. That word is pushed to the queue and the partial count returns to 0.
- R2: Bit 0 of the status register at offset 0xA4 reads 1 exactly while the queue holds at least one word. All status bits other than bits 0 and 4 read 0.
- R3: The queue holds 8 words. A read of offset 0x140 returns the oldest word and removes it. A read of offset 0x140 while the queue is empty returns 0 and removes nothing.
- R4: If a byte would complete a word while the queue is full, that byte is dropped. The packing word and the remaining count stay unchanged, and status bit 4 (overrun) is set.
- R5: A write to offset 0x34 loads the remaining-length counter from bits [15:0]. A read of offset 0x34 returns the counter. Each accepted byte decrements it. While it is 0, arriving bytes are dropped and set overrun. Its reset value is 0.
- R6: A write to the command register at offset 0xA8 with bits [7:4] = 3 (0x30) clears overrun. If overrun is set in the same cycle, setting wins.
- R7: A read of offset 0x50 returns the partial byte count in bits [9:7]. All its other bits read 0.
- R8: A command with bits [11:8] = 4 (0x400) forces a stale flush while stale events are enabled. The flush pushes any partial word into the queue with unused upper lanes zero, clears the partial count, clears the remaining counter, and sets the stale flag (output `staleIrq`). A flush with an empty packing word pushes nothing. A flush whose partial word finds the queue full loses that word and sets overrun. A byte that arrives in a flush cycle is dropped and sets overrun.
- R9: A command with bits [7:4] = 8 (0x80) clears the stale flag. A command with bits [11:8] = 6 (0x600) disables stale events, so later force commands have no effect.
- R10: A command with bits [7:4] = 1 (0x10) resets the receiver. It empties the queue, clears the packing word, the remaining counter, overrun and the stale flag, and re-enables stale events. It takes priority over every other action in that cycle.
- R11: After reset, status, partial count, remaining counter and `staleIrq` are all 0, and stale events are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | A received byte is present this cycle |
| byteData | input | 8 | Received byte |
| busWrite | input | 1 | Register write strobe |
| busRead | input | 1 | Register read strobe (pops on the data offset) |
| busAddr | input | 12 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, valid while busRead is high |
| staleIrq | output | 1 | Stale flag |

## Verification
A register read is checked in the same cycle its strobe is driven, because the read data is combinational. A byte, a command or a pop is first visible one clock edge later, in the partial count, the status bits or the queue head. The bench drives every input on the falling edge, compares read data 1 ns later, and releases the strobes just after the rising edge. Each check therefore observes exactly the state left by the previous edge. Cases that depend on ordering, such as a fourth byte against a full queue, a disabled stale command, or a flush on an empty packing word, are read back through the status, fill-count and data offsets before the next stimulus.

// File: rtl/uartRxPackPkg.sv
package uartRxPackPkg;

  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int PCNT_W = 3;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_RXLEN  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_FILL   = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h140;

  // command codes, low field [7:4]
  localparam logic [3:0] LO_RX_RESET  = 4'h1;
  localparam logic [3:0] LO_CLR_OVR   = 4'h3;
  localparam logic [3:0] LO_CLR_STALE = 4'h8;
  // command codes, high field [11:8]
  localparam logic [3:0] HI_FORCE     = 4'h4;
  localparam logic [3:0] HI_STALE_OFF = 4'h6;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic accept;
    logic flush;
    logic pop;
  } rxStrobes_t;

endpackage

// File: rtl/rxPackData.sv
module rxPackData
  import uartRxPackPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strb,
  input  logic [7:0]        byteData,
  output logic [PCNT_W-1:0] byteCnt,
  output logic [CNT_W-1:0]  fifoCount,
  output logic [WORD_W-1:0] fifoHead,
  output logic              fifoFull
);

  logic [WORD_W-1:0] fullWord;
  logic [WORD_W-1:0] flushWord;
  logic [WORD_W-1:0] pushWord;
  logic              wordDone;
  logic              push;

  assign wordDone = strb.accept && (byteCnt == PCNT_W'(LANES - 1));
  assign fifoFull = (fifoCount == CNT_W'(DEPTH));
  assign push     = wordDone || (strb.flush && (byteCnt != '0) && !fifoFull);
  assign pushWord = wordDone ? fullWord : flushWord;

  // one register per byte lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] laneR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneR <= '0;
      end else if (strb.clear || strb.flush || wordDone) begin
        laneR <= '0;
      end else if (strb.accept && (byteCnt == PCNT_W'(i))) begin
        laneR <= byteData;
      end
    end
    assign fullWord[8*i +: 8]  = (i == LANES - 1) ? byteData : laneR;
    assign flushWord[8*i +: 8] = (PCNT_W'(i) < byteCnt) ? laneR : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (strb.clear || strb.flush || wordDone) begin
      byteCnt <= '0;
    end else if (strb.accept) begin
      byteCnt <= byteCnt + PCNT_W'(1);
    end
  end

  // word queue
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (strb.clear) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (push) wrPtr <= ptrNext(wrPtr);
      if (strb.pop) rdPtr <= ptrNext(rdPtr);
      case ({push, strb.pop})
        2'b10:   fifoCount <= fifoCount + CNT_W'(1);
        2'b01:   fifoCount <= fifoCount - CNT_W'(1);
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  assign fifoHead = mem[rdPtr];

endmodule

// File: rtl/rxPackCtl.sv
module rxPackCtl
  import uartRxPackPkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [PCNT_W-1:0] byteCnt,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [WORD_W-1:0] fifoHead,
  input  logic              fifoFull,
  output rxStrobes_t        strb,
  output logic [WORD_W-1:0] busRdata,
  output logic              staleIrq,
  output logic              overrun
);

  logic             cmdWr;
  logic             lenWr;
  logic [3:0]       cmdLo;
  logic [3:0]       cmdHi;
  logic [LEN_W-1:0] remaining;
  logic             staleEn;
  logic             roomForByte;
  logic             setOvr;
  logic             fifoNonEmpty;

  assign cmdWr = busWrite && (busAddr == OFS_CMD);
  assign lenWr = busWrite && (busAddr == OFS_RXLEN);
  assign cmdLo = busWdata[7:4];
  assign cmdHi = busWdata[11:8];

  assign fifoNonEmpty = (fifoCount != '0);
  assign roomForByte  = !((byteCnt == PCNT_W'(LANES - 1)) && fifoFull);

  always_comb begin
    strb.clear  = cmdWr && (cmdLo == LO_RX_RESET);
    strb.flush  = cmdWr && (cmdHi == HI_FORCE) && staleEn && !strb.clear;
    strb.accept = byteValid && !strb.clear && !strb.flush &&
                  (remaining != '0) && roomForByte;
    strb.pop    = busRead && (busAddr == OFS_DATA) && fifoNonEmpty && !strb.clear;
  end

  assign setOvr = (byteValid && !strb.clear && !strb.accept) ||
                  (strb.flush && (byteCnt != '0) && fifoFull);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (strb.clear || strb.flush) begin
      remaining <= '0;
    end else if (lenWr) begin
      remaining <= busWdata[LEN_W-1:0];
    end else if (strb.accept) begin
      remaining <= remaining - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if (strb.clear) begin
      overrun <= 1'b0;
    end else if (setOvr) begin
      overrun <= 1'b1;
    end else if (cmdWr && (cmdLo == LO_CLR_OVR)) begin
      overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staleIrq <= 1'b0;
      staleEn  <= 1'b1;
    end else if (strb.clear) begin
      staleIrq <= 1'b0;
      staleEn  <= 1'b1;
    end else begin
      if (strb.flush) begin
        staleIrq <= 1'b1;
      end else if (cmdWr && (cmdLo == LO_CLR_STALE)) begin
        staleIrq <= 1'b0;
      end
      if (cmdWr && (cmdHi == HI_STALE_OFF)) staleEn <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRead) begin
      case (busAddr)
        OFS_RXLEN:  busRdata = WORD_W'(remaining);
        OFS_FILL:   busRdata = WORD_W'({byteCnt, 7'b0});
        OFS_STATUS: busRdata = WORD_W'({overrun, 3'b000, fifoNonEmpty});
        OFS_DATA:   busRdata = fifoNonEmpty ? fifoHead : '0;
        default:    busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uartRxPacker.sv
module uartRxPacker
  import uartRxPackPkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        busWrite,
  input  logic        busRead,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        staleIrq
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  rxStrobes_t        strb;
  logic [PCNT_W-1:0] byteCnt;
  logic [CNT_W-1:0]  fifoCount;
  logic [WORD_W-1:0] fifoHead;
  logic              fifoFull;
  logic              overrun;

  rxPackCtl #(
    .LEN_W(LEN_W),
    .CNT_W(CNT_W)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .busWrite (busWrite),
    .busRead  (busRead),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .byteCnt  (byteCnt),
    .fifoCount(fifoCount),
    .fifoHead (fifoHead),
    .fifoFull (fifoFull),
    .strb     (strb),
    .busRdata (busRdata),
    .staleIrq (staleIrq),
    .overrun  (overrun)
  );

  rxPackData #(
    .DEPTH(FIFO_DEPTH)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .byteData (byteData),
    .byteCnt  (byteCnt),
    .fifoCount(fifoCount),
    .fifoHead (fifoHead),
    .fifoFull (fifoFull)
  );

endmodule

// File: rtl/uartRxPackerChk.sv
module uartRxPackerChk
  import uartRxPackPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input rxStrobes_t        strb,
  input logic [PCNT_W-1:0] byteCnt,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              overrun
);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  // R3
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (fifoCount != '0));

  // R1
  pack_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && (byteCnt < PCNT_W'(LANES - 1))) |=>
      (byteCnt == $past(byteCnt) + PCNT_W'(1)));

  // R7
  partial_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= PCNT_W'(LANES - 1));

  // R8
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (byteCnt == '0));

  // R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> ((byteCnt == '0) && (fifoCount == '0) && !overrun));

  // R4
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(byteValid || strb.flush));

endmodule

bind uartRxPacker uartRxPackerChk #(
  .DEPTH(FIFO_DEPTH),
  .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .byteValid(byteValid),
  .strb     (strb),
  .byteCnt  (byteCnt),
  .fifoCount(fifoCount),
  .overrun  (overrun)
);

// File: tb/uartRxPacker_bench.sv
`timescale 1ns/1ps
module uartRxPacker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        staleIrq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uartRxPacker u_uartRxPacker (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .staleIrq(staleIrq)
  );

  localparam logic [11:0] A_LEN  = 12'h034;
  localparam logic [11:0] A_FILL = 12'h050;
  localparam logic [11:0] A_STAT = 12'h0A4;
  localparam logic [11:0] A_CMD  = 12'h0A8;
  localparam logic [11:0] A_DATA = 12'h140;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    @(posedge clk);
    #1 byteValid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1;
    busAddr  = a;
    busWdata = d;
    @(posedge clk);
    #1 busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busRead = 1'b1;
    busAddr = a;
    #1 chk(tag, busRdata, exp);
    @(posedge clk);
    #1 busRead = 1'b0;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    @(negedge clk);
    chk(tag, {31'b0, staleIrq}, {31'b0, exp});
  endtask

  // op: 0 = byte, 1 = write, 2 = read and compare
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 12'h0A4, 32'h0, 32'h0, 4'd11},          // R11 status
    '{2'd2, 12'h050, 32'h0, 32'h0, 4'd11},          // R11 fill
    '{2'd2, 12'h034, 32'h0, 32'h0, 4'd11},          // R11 length
    '{2'd0, 12'h000, 32'h11, 32'h0, 4'd5},          // byte while unarmed
    '{2'd2, 12'h0A4, 32'h0, 32'h10, 4'd5},          // R5 drop sets overrun
    '{2'd1, 12'h0A8, 32'h30, 32'h0, 4'd6},
    '{2'd2, 12'h0A4, 32'h0, 32'h0, 4'd6},           // R6 cleared
    '{2'd1, 12'h034, 32'h6, 32'h0, 4'd5},
    '{2'd2, 12'h034, 32'h0, 32'h6, 4'd5},           // R5 loaded
    '{2'd0, 12'h000, 32'hA1, 32'h0, 4'd1},
    '{2'd0, 12'h000, 32'hB2, 32'h0, 4'd1},
    '{2'd0, 12'h000, 32'hC3, 32'h0, 4'd1},
    '{2'd2, 12'h050, 32'h0, 32'h180, 4'd7},         // R7 three bytes
    '{2'd2, 12'h0A4, 32'h0, 32'h0, 4'd2},           // R2 not ready
    '{2'd0, 12'h000, 32'hD4, 32'h0, 4'd1},
    '{2'd2, 12'h0A4, 32'h0, 32'h1, 4'd2},           // R2 ready
    '{2'd2, 12'h050, 32'h0, 32'h0, 4'd1},           // R1 count wrapped
    '{2'd2, 12'h034, 32'h0, 32'h2, 4'd5},           // R5 decremented
    '{2'd2, 12'h140, 32'h0, 32'hD4C3B2A1, 4'd1},    // R1 lane order
    '{2'd2, 12'h0A4, 32'h0, 32'h0, 4'd3},           // R3 popped
    '{2'd2, 12'h140, 32'h0, 32'h0, 4'd3},           // R3 empty read
    '{2'd0, 12'h000, 32'h55, 32'h0, 4'd1},
    '{2'd0, 12'h000, 32'h66, 32'h0, 4'd1},
    '{2'd0, 12'h000, 32'h77, 32'h0, 4'd5},          // length exhausted
    '{2'd2, 12'h0A4, 32'h0, 32'h10, 4'd5},          // R5 overrun
    '{2'd2, 12'h050, 32'h0, 32'h100, 4'd5},         // R5 dropped byte not packed
    '{2'd1, 12'h0A8, 32'h400, 32'h0, 4'd8},
    '{2'd2, 12'h050, 32'h0, 32'h0, 4'd8},           // R8 count cleared
    '{2'd2, 12'h0A4, 32'h0, 32'h11, 4'd8},          // R8 word pushed
    '{2'd2, 12'h140, 32'h0, 32'h00006655, 4'd8},    // R8 upper lanes zero
    '{2'd1, 12'h0A8, 32'h80, 32'h0, 4'd9},
    '{2'd1, 12'h0A8, 32'h30, 32'h0, 4'd6},
    '{2'd2, 12'h0A4, 32'h0, 32'h0, 4'd6}            // R6
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chkIrq(1'b0, "R11 staleIrq after reset");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        2'd0: sendByte(v.data[7:0]);
        2'd1: wr(v.addr, v.data);
        default: rd(v.addr, v.exp, $sformatf("R%0d vec%0d", v.req, i));
      endcase
    end
    chkIrq(1'b0, "R9 stale flag cleared by 0x80");

    // R8 stale flush of a single byte
    wr(A_LEN, 32'd3);
    sendByte(8'h9A);
    wr(A_CMD, 32'h400);
    chkIrq(1'b1, "R8 stale flag set");
    rd(A_LEN, 32'h0, "R8 flush clears remaining");
    rd(A_DATA, 32'h0000009A, "R8 single byte word");
    wr(A_CMD, 32'h80);
    chkIrq(1'b0, "R9 stale flag clear");

    // R8 flush with empty packing word pushes nothing
    wr(A_LEN, 32'd5);
    wr(A_CMD, 32'h400);
    chkIrq(1'b1, "R8 empty flush sets flag");
    rd(A_STAT, 32'h0, "R8 empty flush pushes nothing");
    wr(A_CMD, 32'h80);

    // R4 queue full: 35 bytes fill 8 words plus 3, the 36th is dropped
    wr(A_LEN, 32'd40);
    for (int k = 0; k < 36; k++) sendByte(8'(k + 1));
    rd(A_STAT, 32'h11, "R4 overrun with full queue");
    rd(A_FILL, 32'h180, "R4 packing word unchanged");
    rd(A_LEN, 32'd5, "R4 dropped byte not counted");
    for (int w = 0; w < 8; w++) begin
      logic [31:0] e;
      e = {8'(4*w + 4), 8'(4*w + 3), 8'(4*w + 2), 8'(4*w + 1)};
      rd(A_DATA, e, $sformatf("R3 queue word %0d", w));
    end
    rd(A_STAT, 32'h10, "R2 ready low after draining");
    rd(A_DATA, 32'h0, "R3 empty read returns zero");

    // R9 stale disable
    wr(A_CMD, 32'h600);
    wr(A_CMD, 32'h400);
    rd(A_FILL, 32'h180, "R9 disabled force leaves packing word");
    chkIrq(1'b0, "R9 disabled force leaves flag");

    // R10 receiver reset
    wr(A_CMD, 32'h10);
    rd(A_FILL, 32'h0, "R10 packing cleared");
    rd(A_STAT, 32'h0, "R10 status cleared");
    rd(A_LEN, 32'h0, "R10 remaining cleared");
    wr(A_LEN, 32'd2);
    sendByte(8'h42);
    wr(A_CMD, 32'h400);
    chkIrq(1'b1, "R10 stale re-enabled");
    rd(A_DATA, 32'h00000042, "R10 flush after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule